// File: doc/BRIEF.md
# Three-Stage Cascaded Delta-Sigma Modulator with Inter-Stage Feedforward

This block turns a fixed fractional word into a stream of small signed integers whose long-run average equals that word divided by 2^N. A fractional-N divider adds this stream to its integer ratio once per reference cycle. The modulator chains three single-bit-quantized accumulators. Each accumulator's overflow carry is its one-bit output, and what is left in the accumulator is the error that the next stage integrates. A noise-shaping combiner then differences the carries of the later stages and merges them into one offset in the range -3..+4.

A build parameter selects between two variants. In the plain variant the last stage integrates only the middle stage's residue. In the feedforward variant the last stage also adds the previous combined output, sign-extended and truncated to the accumulator width. The extra term keeps the last stage from settling into the short cycle the plain variant falls into, so the output sequence repeats less often and fractional spurs come down.

Top module: `mash3_ff_mod`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every accumulator and every delay register is cleared. The offset output reads 0 after each such clock edge.
- R2: Each stage adds its input to an N-bit state at every rising edge. The stage's carry is 1 exactly when the unbounded sum reaches 2^N. The new state and the stage's residue are both the sum modulo 2^N.
- R3: The offset output is a 4-bit two's complement register. It is loaded at each edge with c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where cK is stage K's carry at that edge, ' marks the value one edge earlier and '' two edges earlier. Its value always lies in −3..+4.
- R4: Stage 1 integrates the fractional word and stage 2 integrates stage 1's residue of the same edge. With feedforward enabled (parameter value 1), stage 3 integrates (stage-2 residue + sign-extended current offset output) modulo 2^N.
- R5: With feedforward disabled (parameter value 0), stage 3 integrates the stage-2 residue alone, and the outputs follow R2 and R3.
- R6: Over L consecutive outputs after reset with a constant word F, the output sum differs from L·F/2^N by at most 6, in both variants.
- R7: For odd words at N = 6, the plain variant's output repeats with a period of at most 1024. The feedforward variant's output has either no period up to 1024 or a period longer than the plain one.
- R8: A word of 0 held from reset gives an output of 0 at every edge.
- R9: A new fractional word applied without reset is used from the first edge that samples it, and no reset or flush is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| frac_i | input | ACC_W | Fractional word F; the mean output is F/2^ACC_W |
| offset_o | output | 4 | Signed offset to add to the integer divide ratio |

## Verification
The embedded properties assume that reset is held high at the first clock edge, so every state register starts from a known zero, and that ACC_W is at least the 4-bit output width, so the feedforward term can be sign-extended. The bench asserts reset from time zero and before each new run, and it builds both variants with a 6-bit accumulator. The fractional word may take any value; the bench uses 0, small and large odd words, and a word changed mid-run. Expected outputs come from a cycle model of both variants written in the bench. Mean and repetition period are measured on the captured output stream.

// File: rtl/mash_pkg.sv
`timescale 1ns/1ps
package mash_pkg;

    localparam int OFFSET_W = 4;
    localparam int STAGES   = 3;

    typedef logic signed [OFFSET_W-1:0] offset_t;

    typedef struct packed {
        logic c3;
        logic c2;
        logic c1;
    } carry_vec_t;

    function automatic offset_t widen(input logic b);
        return offset_t'({{(OFFSET_W-1){1'b0}}, b});
    endfunction

    // Noise-shaping combination: first stage direct, second stage first
    // difference, third stage second difference.
    function automatic offset_t combine(input carry_vec_t c,
                                        input logic c2_prev,
                                        input logic c3_prev,
                                        input logic c3_prev2);
        offset_t first_d;
        offset_t second_d;
        first_d  = widen(c.c2) - widen(c2_prev);
        second_d = widen(c.c3) - (widen(c3_prev) <<< 1) + widen(c3_prev2);
        return widen(c.c1) + first_d + second_d;
    endfunction

endpackage

// File: rtl/mash_acc_stage.sv
`timescale 1ns/1ps
module mash_acc_stage #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] addend_i,
    output logic         carry_o,
    output logic [W-1:0] resid_o,
    output logic [W-1:0] acc_o
);
    logic [W:0]   sum_w;
    logic [W-1:0] acc_q;

    assign sum_w   = {1'b0, acc_q} + {1'b0, addend_i};
    assign carry_o = sum_w[W];
    assign resid_o = sum_w[W-1:0];
    assign acc_o   = acc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= '0;
        else       acc_q <= sum_w[W-1:0];
    end

    // R2: an overflow shows as a residue that wrapped below the old state
    a_r2_carry_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        carry_o == (resid_o < acc_q));

endmodule

// File: rtl/mash_noise_cancel.sv
`timescale 1ns/1ps
module mash_noise_cancel
    import mash_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  carry_vec_t carries_i,
    output offset_t    offset_o
);
    logic    c2_d;
    logic    c3_d;
    logic    c3_dd;
    offset_t offset_q;
    offset_t offset_next;

    assign offset_next = combine(carries_i, c2_d, c3_d, c3_dd);
    assign offset_o    = offset_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c2_d     <= 1'b0;
            c3_d     <= 1'b0;
            c3_dd    <= 1'b0;
            offset_q <= '0;
        end else begin
            c2_d     <= carries_i.c2;
            c3_d     <= carries_i.c3;
            c3_dd    <= c3_d;
            offset_q <= offset_next;
        end
    end

    // R3: the shaped offset never leaves -3..+4
    a_r3_offset_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (offset_q >= -4'sd3) && (offset_q <= 4'sd4));

    // R3: a negative offset needs a delayed carry at the edge that produced it
    a_r3_neg_needs_history: assert property (@(posedge clk_i) disable iff (rst_i)
        (offset_q < 0) |-> $past(c2_d || c3_d));

endmodule

// File: rtl/mash3_ff_mod.sv
`timescale 1ns/1ps
module mash3_ff_mod
    import mash_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter bit USE_FF = 1'b1
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [ACC_W-1:0]           frac_i,
    output logic signed [OFFSET_W-1:0] offset_o
);
    localparam int EXT_W = ACC_W - OFFSET_W;

    offset_t            offset_w;
    logic [ACC_W-1:0]   ff_term;
    logic [STAGES-1:0]  carry_bits;
    carry_vec_t         carries;

    // Feedforward term: previous combined output, sign-extended to ACC_W
    if (USE_FF) begin : g_ff_on
        assign ff_term = {{EXT_W{offset_w[OFFSET_W-1]}}, offset_w};
    end else begin : g_ff_off
        assign ff_term = '0;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [ACC_W-1:0] add_in;
        logic [ACC_W-1:0] resid;
        logic [ACC_W-1:0] acc;
        logic             carry;

        if (s == 0) begin : g_src_word
            assign add_in = frac_i;
        end else if (s == STAGES - 1) begin : g_src_last
            assign add_in = g_stage[s-1].resid + ff_term;
        end else begin : g_src_mid
            assign add_in = g_stage[s-1].resid;
        end

        mash_acc_stage #(.W(ACC_W)) u_acc (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .addend_i (add_in),
            .carry_o  (carry),
            .resid_o  (resid),
            .acc_o    (acc)
        );

        assign carry_bits[s] = carry;
    end

    assign carries = carry_vec_t'({carry_bits[2], carry_bits[1], carry_bits[0]});

    mash_noise_cancel u_cancel (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .carries_i (carries),
        .offset_o  (offset_w)
    );

    assign offset_o = offset_w;

    // R8: an empty first accumulator fed a zero word cannot overflow
    a_r8_idle_no_carry: assert property (@(posedge clk_i) disable iff (rst_i)
        ((frac_i == '0) && (g_stage[0].acc == '0)) |-> !carry_bits[0]);

endmodule

// File: tb/mash3_ff_mod_tb_top.sv
`timescale 1ns/1ps
module mash3_ff_mod_tb_top;

    localparam int N     = 6;
    localparam int MASK  = (1 << N) - 1;
    localparam int T0    = 64;
    localparam int WIN   = 1024;
    localparam int PMAX  = 1024;
    localparam int RUN   = 2200;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N-1:0]       frac = '0;
    logic signed [3:0]  off_ff;
    logic signed [3:0]  off_pl;

    always #5 clk = ~clk;

    mash3_ff_mod #(.ACC_W(N), .USE_FF(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .frac_i(frac), .offset_o(off_ff));

    mash3_ff_mod #(.ACC_W(N), .USE_FF(1'b0)) dut_plain_i (
        .clk_i(clk), .rst_i(rst), .frac_i(frac), .offset_o(off_pl));

    typedef struct {
        int a1; int a2; int a3; int c2d; int c3d; int c3dd; int yq;
    } mstate_t;

    typedef struct {
        int    e_ff;
        int    e_pl;
        bit    in_rst;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       cap_ff[$];
    int       cap_pl[$];
    int       n_vec = 0;
    int       n_bad = 0;
    mstate_t  m_ff;
    mstate_t  m_pl;

    // Cycle model written from R2..R5
    function automatic mstate_t model_step(mstate_t s, int f, bit ff);
        mstate_t ns;
        int s1, c1, r1, s2, c2, r2, in3, s3, c3, y;
        s1  = s.a1 + f;    c1 = s1 >> N; r1 = s1 & MASK;
        s2  = s.a2 + r1;   c2 = s2 >> N; r2 = s2 & MASK;
        in3 = ff ? ((r2 + s.yq) & MASK) : r2;
        s3  = s.a3 + in3;  c3 = s3 >> N;
        y   = c1 + c2 - s.c2d + c3 - 2 * s.c3d + s.c3dd;
        ns.a1 = r1; ns.a2 = r2; ns.a3 = s3 & MASK;
        ns.c2d = c2; ns.c3dd = s.c3d; ns.c3d = c3; ns.yq = y;
        return ns;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: sets inputs for the coming edge and queues the expected result
    task automatic drive(bit r, int f, string tag);
        sb_item_t it;
        rst  = r;
        frac = f[N-1:0];
        if (r) begin
            m_ff = '{default: 0};
            m_pl = '{default: 0};
        end else begin
            m_ff = model_step(m_ff, f & MASK, 1'b1);
            m_pl = model_step(m_pl, f & MASK, 1'b0);
        end
        it.e_ff = m_ff.yq; it.e_pl = m_pl.yq; it.in_rst = r; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compares each edge's outputs against the queued prediction
    always @(posedge clk) begin
        sb_item_t it;
        int a_ff, a_pl;
        #2;
        if (sb_q.size() > 0) begin
            it   = sb_q.pop_front();
            a_ff = int'(off_ff);
            a_pl = int'(off_pl);
            check(a_ff == it.e_ff, it.tag, "R3 R4 feedforward offset", a_ff, it.e_ff);
            check(a_pl == it.e_pl, it.tag, "R3 R5 plain offset", a_pl, it.e_pl);
            if (!it.in_rst) begin
                cap_ff.push_back(a_ff);
                cap_pl.push_back(a_pl);
            end
        end
    end

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        #4;
    endtask

    function automatic int min_period(int c[$]);
        for (int p = 1; p <= PMAX; p++) begin
            bit ok = 1'b1;
            for (int n = 0; n < WIN; n++) begin
                if (c[T0 + n] != c[T0 + n + p]) begin
                    ok = 1'b0;
                    break;
                end
            end
            if (ok) return p;
        end
        return 0;
    endfunction

    task automatic run_word(int w, bit do_period);
        int sum_ff, sum_pl, len, pf, pp;
        repeat (2) drive(1'b1, 0, "R1");
        drain();
        cap_ff.delete();
        cap_pl.delete();
        repeat (RUN) drive(1'b0, w, "R2");
        drain();
        len = cap_ff.size();
        sum_ff = 0; sum_pl = 0;
        foreach (cap_ff[i]) sum_ff += cap_ff[i];
        foreach (cap_pl[i]) sum_pl += cap_pl[i];
        // R6: |sum*2^N - L*F| <= 6*2^N
        check((sum_ff * 64 - len * w <= 384) && (len * w - sum_ff * 64 <= 384),
              "R6", "feedforward mean x64", sum_ff * 64, len * w);
        check((sum_pl * 64 - len * w <= 384) && (len * w - sum_pl * 64 <= 384),
              "R6", "plain mean x64", sum_pl * 64, len * w);
        if (do_period) begin
            pp = min_period(cap_pl);
            pf = min_period(cap_ff);
            check(pp != 0, "R7", "plain period found", pp, PMAX);
            check((pf == 0) || (pf > pp), "R7", "feedforward period exceeds plain", pf, pp);
        end
    endtask

    initial begin
        int words[4] = '{1, 5, 21, 63};
        m_ff = '{default: 0};
        m_pl = '{default: 0};
        // R1: reset state
        repeat (3) drive(1'b1, 17, "R1");
        drain();
        check(off_ff == 4'sd0, "R1", "feedforward offset in reset", int'(off_ff), 0);
        check(off_pl == 4'sd0, "R1", "plain offset in reset", int'(off_pl), 0);
        // R8: zero word from reset
        repeat (40) drive(1'b0, 0, "R8");
        drain();
        check(off_ff == 4'sd0, "R8", "feedforward offset on zero word", int'(off_ff), 0);
        // R2..R7: odd words, exact sequence, mean and period
        foreach (words[k]) run_word(words[k], 1'b1);
        // R6: even word, mean only
        run_word(32, 1'b0);
        // R9: word changes without reset
        repeat (2) drive(1'b1, 0, "R1");
        repeat (120) drive(1'b0, 10, "R9");
        repeat (120) drive(1'b0, 50, "R9");
        repeat (120) drive(1'b0, 3, "R9");
        drain();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog R1..R9 run: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule